// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block measures the rate of an incoming clock (the measured clock) against a stable reference clock and reports it as an unsigned integer in tenths of a megahertz. A free-running counter in the measured domain divides that clock by a power of two. It publishes its count in Gray code, and a synchronizer moves the count into the reference domain. Each gate period is a fixed number of reference cycles. At the end of each one, the difference between two successive samples is the new frequency value, and it is reported with a one-cycle strobe.

The value is held between strobes. It is then compared against a low and a high limit, both stored in tenths of a megahertz, to produce a health flag. The flag is true only when the frequency lies strictly inside the open window. It exists for an indicator and has no influence on anything else. Values above the measurement ceiling are clamped to that ceiling. When the measured clock stops, the counter freezes, the next results read zero and the flag drops.

The parameter `REF_TICKS` is the number of reference cycles in 10 microseconds. The gate period is `REF_TICKS << PRESC_LOG2` reference cycles, so one count of the divided clock over one gate period equals 0.1 MHz. The result is a plain strobe with no ready. It cannot be back-pressured: a consumer that misses a strobe reads the held value until the next one.

Top module: `freq_window_mon`

## Requirements
- R1: While `rst_n` is low, `freq_tenths` is 0, `freq_valid` is 0 and `in_window` is 0.
- R2: `freq_valid` is a single-cycle pulse. The first pulse comes on the reference cycle after edge 2·GATE counted from reset release, where GATE = `REF_TICKS << PRESC_LOG2`. After that, a pulse comes exactly every GATE reference cycles.
- R3: With a steady measured clock, each reported value equals the number of measured-clock cycles in one gate period divided by 2^`PRESC_LOG2`. This is the frequency in 0.1 MHz units.
- R4: A count above `MAX_TENTHS` is reported as `MAX_TENTHS`.
- R5: `in_window` is 1 only when low limit < `freq_tenths` < high limit. A value equal to either limit gives 0.
- R6: `in_window` follows a change of `freq_tenths` or of a limit exactly one reference cycle later.
- R7: A cycle with `lo_wr` high loads `lim_data` into the low limit. A cycle with `hi_wr` high loads it into the high limit. Both high in the same cycle loads both.
- R8: When the measured clock stops, the reported value becomes 0 within two strobes, and `in_window` reads 0.
- R9: `freq_tenths` changes only in a cycle where `freq_valid` is 1, and holds its value otherwise.
- R10: After reset the low limit is `LO_DEFAULT` (0) and the high limit is `HI_DEFAULT` (30000, i.e. 3000.0 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Stable reference clock; all outputs are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| meas_clk | input | 1 | Clock being measured; may stop |
| lo_wr | input | 1 | Load `lim_data` into the low limit |
| hi_wr | input | 1 | Load `lim_data` into the high limit |
| lim_data | input | FREQ_W | Limit value in 0.1 MHz units |
| freq_tenths | output | FREQ_W | Latest measured frequency in 0.1 MHz units |
| freq_valid | output | 1 | One-cycle strobe marking a new `freq_tenths` |
| in_window | output | 1 | Frequency is strictly inside the limit window |

## Verification
Corrupted gate timing shows up at once as a strobe in the wrong cycle. The bench checks `freq_valid` against its own edge count in every reference cycle. A corrupted sample, Gray conversion or difference shows up at the first settled strobe as a value that differs from the count the bench derives from the measured-clock period. A wrong comparison or limit register shows up one cycle after the value or limit changes, because the bench predicts `in_window` in every cycle from the previous cycle's value and limits. This includes the equality cases at both limits and the zero reading with the clock stopped.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

  localparam int unsigned SYNC_STAGES_DEF = 2;

  // Gate period in reference cycles: base 10 us window stretched by the
  // measured-clock prescaler so one divided count still means 0.1 MHz.
  function automatic int unsigned gate_cycles(input int unsigned ticks,
                                              input int unsigned presc_log2);
    return ticks << presc_log2;
  endfunction

endpackage

// File: rtl/fwm_meas_count.sv
module fwm_meas_count #(
  parameter int unsigned PRESC_LOG2 = 2,
  parameter int unsigned CNT_W      = 17
) (
  input  logic             meas_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_o
);

  localparam int unsigned RAW_W = CNT_W + PRESC_LOG2;

  logic [1:0]       run_sync;
  logic [RAW_W-1:0] raw_cnt;
  logic [CNT_W-1:0] div_cnt;

  // Reset release is synchronised into the measured domain.
  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) run_sync <= '0;
    else        run_sync <= {run_sync[0], 1'b1};
  end

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n)           raw_cnt <= '0;
    else if (run_sync[1]) raw_cnt <= raw_cnt + 1'b1;
  end

  generate
    if (PRESC_LOG2 == 0) begin : g_nodiv
      assign div_cnt = raw_cnt;
    end else begin : g_div
      assign div_cnt = raw_cnt[RAW_W-1:PRESC_LOG2];
    end
  endgenerate

  // Registered Gray form: one bit flips per divided count.
  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) gray_o <= '0;
    else        gray_o <= div_cnt ^ (div_cnt >> 1);
  end

endmodule

// File: rtl/fwm_gray_sync.sv
module fwm_gray_sync #(
  parameter int unsigned W      = 17,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= gray_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_comb begin
    bin_o[W-1] = stg[STAGES-1][W-1];
    for (int i = int'(W) - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ stg[STAGES-1][i];
    end
  end

endmodule

// File: rtl/fwm_gate.sv
module fwm_gate #(
  parameter int unsigned GATE       = 4000,
  parameter int unsigned CNT_W      = 17,
  parameter int unsigned FREQ_W     = 15,
  parameter int unsigned MAX_TENTHS = 30400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  bin_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic              valid_o
);

  localparam int unsigned GCW = (GATE > 2) ? $clog2(GATE) : 1;
  localparam logic [GCW-1:0]    LAST_TICK = GCW'(GATE - 1);
  localparam logic [CNT_W-1:0]  CEIL_CNT  = CNT_W'(MAX_TENTHS);
  localparam logic [FREQ_W-1:0] CEIL_OUT  = FREQ_W'(MAX_TENTHS);

  logic [GCW-1:0]    gate_cnt;
  logic [CNT_W-1:0]  last_smp;
  logic [CNT_W-1:0]  delta;
  logic [FREQ_W-1:0] clamped;
  logic              primed;
  logic              tick;

  assign tick    = (gate_cnt == LAST_TICK);
  assign delta   = bin_i - last_smp;
  assign clamped = (delta > CEIL_CNT) ? CEIL_OUT : delta[FREQ_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_cnt <= '0;
      last_smp <= '0;
      primed   <= 1'b0;
      freq_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick) begin
        gate_cnt <= '0;
        last_smp <= bin_i;
        primed   <= 1'b1;
        if (primed) begin
          freq_o  <= clamped;
          valid_o <= 1'b1;
        end
      end else begin
        gate_cnt <= gate_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/freq_window_mon.sv
module freq_window_mon #(
  parameter int unsigned REF_TICKS   = 1000,
  parameter int unsigned PRESC_LOG2  = 2,
  parameter int unsigned FREQ_W      = 15,
  parameter int unsigned MAX_TENTHS  = 30400,
  parameter int unsigned LO_DEFAULT  = 0,
  parameter int unsigned HI_DEFAULT  = 30000,
  parameter int unsigned SYNC_STAGES = fwm_pkg::SYNC_STAGES_DEF
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              meas_clk,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [FREQ_W-1:0] lim_data,
  output logic [FREQ_W-1:0] freq_tenths,
  output logic              freq_valid,
  output logic              in_window
);

  localparam int unsigned GATE  = fwm_pkg::gate_cycles(REF_TICKS, PRESC_LOG2);
  localparam int unsigned CNT_W = FREQ_W + 2;

  logic [CNT_W-1:0]  gray_meas;
  logic [CNT_W-1:0]  bin_ref;
  logic [FREQ_W-1:0] lo_q;
  logic [FREQ_W-1:0] hi_q;

  fwm_meas_count #(.PRESC_LOG2(PRESC_LOG2), .CNT_W(CNT_W)) u_meas (
    .meas_clk (meas_clk),
    .rst_n    (rst_n),
    .gray_o   (gray_meas)
  );

  fwm_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .gray_i (gray_meas),
    .bin_o  (bin_ref)
  );

  fwm_gate #(.GATE(GATE), .CNT_W(CNT_W), .FREQ_W(FREQ_W),
             .MAX_TENTHS(MAX_TENTHS)) u_gate (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .bin_i   (bin_ref),
    .freq_o  (freq_tenths),
    .valid_o (freq_valid)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= FREQ_W'(LO_DEFAULT);
      hi_q <= FREQ_W'(HI_DEFAULT);
    end else begin
      if (lo_wr) lo_q <= lim_data;
      if (hi_wr) hi_q <= lim_data;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) in_window <= 1'b0;
    else        in_window <= (lo_q < freq_tenths) && (freq_tenths < hi_q);
  end

endmodule

// File: rtl/fwm_checker.sv
module fwm_checker #(
  parameter int unsigned REF_TICKS  = 1000,
  parameter int unsigned PRESC_LOG2 = 2,
  parameter int unsigned FREQ_W     = 15,
  parameter int unsigned MAX_TENTHS = 30400
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FREQ_W-1:0] freq,
  input logic              valid,
  input logic              in_win,
  input logic [FREQ_W-1:0] lo,
  input logic [FREQ_W-1:0] hi
);

  localparam int unsigned GATE = fwm_pkg::gate_cycles(REF_TICKS, PRESC_LOG2);

  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (valid) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && seen) |-> (gap == GATE - 1));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_value_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    freq <= FREQ_W'(MAX_TENTHS));

  assert_open_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (($past(lo) < $past(freq)) && ($past(freq) < $past(hi))));

  assert_value_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(freq));

endmodule

bind freq_window_mon fwm_checker #(
  .REF_TICKS(REF_TICKS), .PRESC_LOG2(PRESC_LOG2),
  .FREQ_W(FREQ_W), .MAX_TENTHS(MAX_TENTHS)
) u_fwm_checker (
  .clk    (ref_clk),
  .rst_n  (rst_n),
  .freq   (freq_tenths),
  .valid  (freq_valid),
  .in_win (in_window),
  .lo     (lo_q),
  .hi     (hi_q)
);

// File: tb/test_freq_window_mon.sv
`timescale 1ps/1ps
module test_freq_window_mon;

  localparam int RT   = 25;
  localparam int PL   = 1;
  localparam int G    = RT << PL;
  localparam int FW   = 8;
  localparam int MAXV = 60;
  localparam int LOD  = 0;
  localparam int HID  = 55;

  logic          ref_clk = 1'b0;
  logic          meas_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lo_wr = 1'b0;
  logic          hi_wr = 1'b0;
  logic [FW-1:0] lim_data = '0;
  logic [FW-1:0] freq_tenths;
  logic          freq_valid;
  logic          in_window;

  freq_window_mon #(.REF_TICKS(RT), .PRESC_LOG2(PL), .FREQ_W(FW),
    .MAX_TENTHS(MAXV), .LO_DEFAULT(LOD), .HI_DEFAULT(HID)) i_freq_window_mon (
    .ref_clk(ref_clk), .rst_n(rst_n), .meas_clk(meas_clk),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .lim_data(lim_data),
    .freq_tenths(freq_tenths), .freq_valid(freq_valid), .in_window(in_window));

  // 250 MHz reference
  always #2000 ref_clk = ~ref_clk;

  // Measured clock: half period in ps, 0 means stopped. Edges stay at
  // 333 ps mod 500 ps, away from every reference edge.
  int m_half = 1000;
  initial begin
    #333;
    forever begin
      if (m_half > 0) begin
        #(m_half) meas_clk = ~meas_clk;
      end else begin
        meas_clk = 1'b0;
        #1000;
      end
    end
  end

  int    checks = 0;
  int    errors = 0;
  int    n_edges = 0;
  int    exp_freq = 50;
  int    skip = 1;
  string tag = "R3";
  int    lo_m = LOD, hi_m = HID;
  int    prev_freq = 0, prev_lo = LOD, prev_hi = HID;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of the edge count and the limit registers.
  always @(posedge ref_clk) begin
    if (rst_n) begin
      n_edges++;
      if (lo_wr) lo_m = int'(lim_data);
      if (hi_wr) hi_m = int'(lim_data);
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge ref_clk) begin
    if (rst_n && !done) begin
      bit exp_v;
      bit exp_w;
      exp_v = (n_edges >= 2 * G) && (n_edges % G == 0);
      chk(freq_valid == exp_v, "R2 strobe timing", int'(freq_valid), int'(exp_v));
      if (freq_valid) begin
        if (skip > 0) skip--;
        else chk(int'(freq_tenths) == exp_freq, tag, int'(freq_tenths), exp_freq);
      end else begin
        chk(int'(freq_tenths) == prev_freq, "R9 hold", int'(freq_tenths), prev_freq);
      end
      exp_w = (prev_lo < prev_freq) && (prev_freq < prev_hi);
      chk(in_window == exp_w, "R5/R6 window", int'(in_window), int'(exp_w));
      prev_freq = int'(freq_tenths);
      prev_lo   = lo_m;
      prev_hi   = hi_m;
    end
  end

  task automatic write_lim(input bit wl, input bit wh, input int v);
    @(negedge ref_clk);
    lo_wr = wl; hi_wr = wh; lim_data = FW'(v);
    @(negedge ref_clk);
    lo_wr = 1'b0; hi_wr = 1'b0;
  endtask

  task automatic set_meas(input int half, input int expv, input string t);
    @(negedge ref_clk);
    m_half = half; exp_freq = expv; tag = t; skip = 2;
  endtask

  initial begin
    repeat (5) @(negedge ref_clk);
    chk(freq_tenths == '0, "R1 reset value", int'(freq_tenths), 0);
    chk(freq_valid == 1'b0, "R1 reset strobe", int'(freq_valid), 0);
    chk(in_window == 1'b0, "R1 reset window", int'(in_window), 0);
    rst_n = 1'b1;
    repeat (5 * G) @(negedge ref_clk);
    // 2 ns period, 2^PL=2: 100 cycles per gate / 2 = 50; defaults 0 and 55
    chk(in_window == 1'b1, "R10 default limits", int'(in_window), 1);

    write_lim(1'b0, 1'b1, 50);           // hi equals value
    @(negedge ref_clk);
    chk(in_window == 1'b0, "R5 equal high", int'(in_window), 0);
    write_lim(1'b0, 1'b1, 51);
    @(negedge ref_clk);
    chk(in_window == 1'b1, "R6 limit change", int'(in_window), 1);
    write_lim(1'b1, 1'b0, 50);           // lo equals value
    @(negedge ref_clk);
    chk(in_window == 1'b0, "R5 equal low", int'(in_window), 0);
    write_lim(1'b1, 1'b1, 10);           // both loaded in one cycle
    @(negedge ref_clk);
    chk(in_window == 1'b0, "R7 both written", int'(in_window), 0);
    write_lim(1'b0, 1'b1, 200);
    @(negedge ref_clk);
    chk(in_window == 1'b1, "R7 high written", int'(in_window), 1);

    set_meas(2500, 20, "R3 5ns period");
    repeat (5 * G) @(negedge ref_clk);
    chk(int'(freq_tenths) == 20, "R3 slow clock", int'(freq_tenths), 20);

    set_meas(500, MAXV, "R4 ceiling");
    repeat (5 * G) @(negedge ref_clk);
    chk(int'(freq_tenths) == MAXV, "R4 clamped", int'(freq_tenths), MAXV);

    write_lim(1'b1, 1'b0, 0);
    set_meas(0, 0, "R8 stopped");
    repeat (5 * G) @(negedge ref_clk);
    chk(int'(freq_tenths) == 0, "R8 zero value", int'(freq_tenths), 0);
    chk(in_window == 1'b0, "R8 window low", int'(in_window), 0);

    set_meas(2000, 25, "R3 4ns period");
    repeat (4 * G) @(negedge ref_clk);
    chk(int'(freq_tenths) == 25, "R3 restart", int'(freq_tenths), 25);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule